// File: doc/BRIEF.md
# Resampling Phase Accumulator with Decimation Divider

This block sets the output sample timing of a decimating receiver. A 32-bit phase accumulator advances on every qualified input sample by the sum of two frequency words. One is a center word written over a parallel register port. The other is an offset word shifted in serially and made active by a sync pulse. Each time the accumulator wraps, it emits a one-cycle carry strobe. A programmable divider turns either these carries or the raw qualified samples into a one-cycle decimation strobe for downstream decimating filters.

A mode bit picks between the two divider sources. In fixed-rate mode the divider counts every qualified sample, so the decimation factor equals the divisor. In accumulator-driven mode it counts carries, so the factor becomes divisor × Fs / carry rate, where the carry rate is Fs × (center + offset) / 2^32. A 5-bit slice of the upper accumulator bits is also exported, together with the carry strobe, so that an external interpolating filter can refine sample timing below one input sample.

Top module: `rsmp_nco_top`

## Requirements
- R1: On each qualified sample the accumulator becomes (acc + center + offset) mod 2^32. `carry_stb` is high for exactly the one cycle following an update that wrapped past 2^32, and is low otherwise.
- R2: When `gated_mode`=1 the accumulator advances only on clock edges where `samp_en`=1 and otherwise holds its value. When `gated_mode`=0 it advances on every clock.
- R3: A clock edge with `cfw_wr`=1 loads `cfw_data` as the center word. That word is used by later accumulator updates.
- R4: On each edge with `ofs_sen`=1, `ofs_sdata` shifts into a 32-bit staging register, MSB first. The staged word becomes the active offset only on the second edge after `ofs_sync` is sampled high. Until then, shifting has no effect on the accumulator.
- R5: `phase_win` equals accumulator bits [31-`win_sel` : 27-`win_sel`]. A `win_sel` of 0 selects the top five bits, and each step of `win_sel` moves the window one bit toward the LSB.
- R6: With `nco_mode`=0, `dec_stb` pulses once per `div_value` qualified samples.
- R7: With `nco_mode`=1, `dec_stb` pulses once per `div_value` carry strobes.
- R8: `div_value` is valid from 1 to 4096. At 1, every counted event gives a strobe. At 4096, strobes are 4096 events apart. The divider reloads on its terminal count, and `dec_stb` is a single-cycle pulse.
- R9: After reset, `carry_stb`, `dec_stb` and `phase_win` are 0, and the accumulator, both frequency words and the divider count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gated_mode | input | 1 | 1: advance only when `samp_en` is high; 0: advance every clock |
| samp_en | input | 1 | Input sample qualifier used in gated mode |
| cfw_wr | input | 1 | Center-word write strobe |
| cfw_data | input | 32 | Center-word write data |
| ofs_sen | input | 1 | Serial shift enable for the offset word |
| ofs_sdata | input | 1 | Serial offset data, MSB first |
| ofs_sync | input | 1 | Transfers the staged offset word into the active register |
| nco_mode | input | 1 | 1: divider counts carries; 0: divider counts qualified samples |
| div_value | input | 13 | Divisor, 1 to 4096 |
| win_sel | input | 2 | Phase-window offset from the MSB, 0 to 3 |
| carry_stb | output | 1 | Accumulator wrap strobe |
| phase_win | output | 5 | Selected 5-bit phase slice |
| dec_stb | output | 1 | Decimation strobe |

## Verification
The hardest state to reach from the ports is a known accumulator value at which the phase window and the wrap can be checked bit by bit. In free-running operation the accumulator moves on every clock. The bench therefore works in gated mode and issues single `samp_en` pulses, so the accumulator steps exactly once per pulse and holds in between. It then reads all four window offsets while the value is frozen, and provokes a wrap with a second step. Decimation rates are measured as the cycle gap between consecutive strobes, taken after the first strobe so that the divider starts from a reload. Power-of-two frequency words make the carry period exact.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;
  localparam int ACC_W_D = 32;  // phase accumulator width
  localparam int WIN_W_D = 5;   // exported phase window width
  localparam int TOP_W_D = 8;   // upper bits the window may slide over
  localparam int DIV_W_D = 13;  // divisor width, holds 1..4096

  typedef enum logic {
    SRC_SAMPLE = 1'b0,
    SRC_CARRY  = 1'b1
  } div_src_e;
endpackage

// File: rtl/rsmp_ofs_loader.sv
module rsmp_ofs_loader #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sen,
  input  logic             sdata,
  input  logic             sync,
  output logic [ACC_W-1:0] ofs_word
);
  logic [ACC_W-1:0] stage_q, stage_d;
  logic [ACC_W-1:0] ofs_q, ofs_d;
  logic             sync_q;

  always_comb begin
    stage_d = stage_q;
    if (sen) stage_d = {stage_q[ACC_W-2:0], sdata};
    ofs_d = ofs_q;
    if (sync_q) ofs_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ofs_q   <= '0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      ofs_q   <= ofs_d;
      sync_q  <= sync;
    end
  end

  assign ofs_word = ofs_q;

  // R4
  ofs_only_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofs_q) |-> $past(sync_q));
endmodule

// File: rtl/rsmp_phase_acc.sv
module rsmp_phase_acc #(
  parameter int ACC_W = 32,
  parameter int WIN_W = 5,
  parameter int TOP_W = 8,
  localparam int NWIN  = TOP_W - WIN_W + 1,
  localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [ACC_W-1:0] cf_word,
  input  logic [ACC_W-1:0] ofs_word,
  input  logic [SEL_W-1:0] win_sel,
  output logic             carry,
  output logic [WIN_W-1:0] phase_win
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             carry_q, carry_d;
  logic [ACC_W:0]   step_sum;
  logic [ACC_W:0]   nxt_sum;
  logic [WIN_W-1:0] win_arr [NWIN];

  always_comb begin
    step_sum = {1'b0, cf_word} + {1'b0, ofs_word};
    nxt_sum  = {1'b0, acc_q} + {1'b0, step_sum[ACC_W-1:0]};
    acc_d    = acc_q;
    carry_d  = 1'b0;
    if (adv) begin
      acc_d   = nxt_sum[ACC_W-1:0];
      carry_d = nxt_sum[ACC_W] | step_sum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_arr[g] = acc_q[ACC_W-1-g -: WIN_W];
  end

  assign phase_win = win_arr[win_sel];
  assign carry     = carry_q;

  // R1
  carry_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |-> $past(adv));
  // R2
  hold_without_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_q));
endmodule

// File: rtl/rsmp_rate_div.sv
module rsmp_rate_div #(
  parameter int DIV_W = 13,
  localparam int CNT_W = DIV_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [DIV_W-1:0] div_value,
  output logic             dec_stb
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic [DIV_W-1:0] div_eff;
  logic             term;

  always_comb begin
    div_eff = (div_value == '0) ? DIV_W'(1) : div_value;
    term    = ({1'b0, cnt_q} + DIV_W'(1)) >= div_eff;
    cnt_d   = cnt_q;
    stb_d   = 1'b0;
    if (evt) begin
      if (term) begin
        cnt_d = '0;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign dec_stb = stb_q;

  // R8
  strobe_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(evt));
  // R8
  count_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(div_value) && evt |=> ({1'b0, cnt_q} < div_eff));
endmodule

// File: rtl/rsmp_nco_top.sv
module rsmp_nco_top
  import rsmp_pkg::*;
#(
  parameter int ACC_W = ACC_W_D,
  parameter int WIN_W = WIN_W_D,
  parameter int TOP_W = TOP_W_D,
  parameter int DIV_W = DIV_W_D,
  localparam int NWIN  = TOP_W - WIN_W + 1,
  localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gated_mode,
  input  logic             samp_en,
  input  logic             cfw_wr,
  input  logic [ACC_W-1:0] cfw_data,
  input  logic             ofs_sen,
  input  logic             ofs_sdata,
  input  logic             ofs_sync,
  input  logic             nco_mode,
  input  logic [DIV_W-1:0] div_value,
  input  logic [SEL_W-1:0] win_sel,
  output logic             carry_stb,
  output logic [WIN_W-1:0] phase_win,
  output logic             dec_stb
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic [ACC_W-1:0] cf_q, cf_d;
  logic [ACC_W-1:0] ofs_word;
  logic             qual;
  logic             carry;
  logic             div_evt;
  div_src_e         src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  always_comb begin
    cf_d = cf_q;
    if (cfw_wr) cf_d = cfw_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cf_q <= '0;
    else          cf_q <= cf_d;
  end

  assign qual    = gated_mode ? samp_en : 1'b1;
  assign src     = div_src_e'(nco_mode);
  assign div_evt = (src == SRC_CARRY) ? carry : qual;

  rsmp_ofs_loader #(.ACC_W(ACC_W)) ofs_i (
    .clk(clk), .rst_n(rst_n_s), .sen(ofs_sen), .sdata(ofs_sdata),
    .sync(ofs_sync), .ofs_word(ofs_word)
  );

  rsmp_phase_acc #(.ACC_W(ACC_W), .WIN_W(WIN_W), .TOP_W(TOP_W)) acc_i (
    .clk(clk), .rst_n(rst_n_s), .adv(qual), .cf_word(cf_q),
    .ofs_word(ofs_word), .win_sel(win_sel), .carry(carry),
    .phase_win(phase_win)
  );

  rsmp_rate_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n_s), .evt(div_evt), .div_value(div_value),
    .dec_stb(dec_stb)
  );

  assign carry_stb = carry;

  // R3
  cf_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfw_wr |=> (cf_q == $past(cfw_data)));
  // R9
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n_s |-> (!carry_stb && !dec_stb));
endmodule

// File: tb/rsmp_nco_top_tb_top.sv
module rsmp_nco_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gated_mode, en_force, en_alt, samp_en;
  logic        tog = 1'b0;
  logic        cfw_wr, ofs_sen, ofs_sdata, ofs_sync, nco_mode;
  logic [31:0] cfw_data;
  logic [12:0] div_value;
  logic [1:0]  win_sel;
  logic        carry_stb, dec_stb;
  logic [4:0]  phase_win;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tog <= ~tog;
  assign samp_en = en_force | (en_alt & tog);

  rsmp_nco_top dut_i (
    .clk(clk), .rst_n(rst_n), .gated_mode(gated_mode), .samp_en(samp_en),
    .cfw_wr(cfw_wr), .cfw_data(cfw_data), .ofs_sen(ofs_sen),
    .ofs_sdata(ofs_sdata), .ofs_sync(ofs_sync), .nco_mode(nco_mode),
    .div_value(div_value), .win_sel(win_sel), .carry_stb(carry_stb),
    .phase_win(phase_win), .dec_stb(dec_stb)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit gm, input bit nm, input int dv);
    @(negedge clk);
    rst_n = 1'b0; gated_mode = gm; nco_mode = nm; div_value = 13'(dv);
    en_force = 0; en_alt = 0; cfw_wr = 0; cfw_data = '0;
    ofs_sen = 0; ofs_sdata = 0; ofs_sync = 0; win_sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cf(input logic [31:0] v);
    @(negedge clk); cfw_wr = 1; cfw_data = v;
    @(negedge clk); cfw_wr = 0;
  endtask

  task automatic load_ofs(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); ofs_sen = 1; ofs_sdata = v[i];
    end
    @(negedge clk); ofs_sen = 0; ofs_sync = 1;
    @(negedge clk); ofs_sync = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic step_once();
    @(negedge clk); en_force = 1;
    @(negedge clk); en_force = 0;
  endtask

  task automatic gap(input bit use_carry, output int n);
    int lim = 20000;
    n = 0;
    do @(negedge clk); while (!(use_carry ? carry_stb : dec_stb) && --lim > 0);
    do begin @(negedge clk); n++; end while (!(use_carry ? carry_stb : dec_stb) && n < 20000);
  endtask

  task automatic t_reset_state();
    do_reset(1, 0, 8);
    chk(carry_stb == 0, "R9 carry", carry_stb, 0);
    chk(dec_stb == 0, "R9 dec", dec_stb, 0);
    chk(phase_win == 0, "R9 phase", phase_win, 0);
  endtask

  task automatic t_window_and_wrap();
    logic [4:0] exp_w [4] = '{5'h16, 5'h0D, 5'h1A, 5'h14};
    do_reset(1, 0, 8);
    write_cf(32'hB400_0000);
    step_once();
    chk(carry_stb == 0, "R1 no carry first step", carry_stb, 0);
    for (int s = 0; s < 4; s++) begin
      win_sel = 2'(s);
      #1 chk(phase_win == exp_w[s], "R5 window", phase_win, exp_w[s]);
      @(negedge clk);
    end
    win_sel = 0;
    repeat (5) @(negedge clk);
    chk(phase_win == 5'h16, "R2 hold when samp_en low", phase_win, 5'h16);
    step_once();
    chk(carry_stb == 1, "R1 carry on wrap", carry_stb, 1);
    chk(phase_win == 5'h0D, "R1 wrapped value", phase_win, 5'h0D);
    @(negedge clk);
    chk(carry_stb == 0, "R1 carry one cycle", carry_stb, 0);
  endtask

  task automatic t_serial();
    do_reset(1, 0, 8);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); ofs_sen = 1; ofs_sdata = (i == 30);
    end
    @(negedge clk); ofs_sen = 0;
    step_once();
    chk(phase_win == 0, "R4 no effect before sync", phase_win, 0);
    @(negedge clk); ofs_sync = 1;
    @(negedge clk); ofs_sync = 0;
    repeat (2) @(negedge clk);
    step_once();
    chk(phase_win == 5'h08, "R4 MSB-first offset", phase_win, 5'h08);
  endtask

  task automatic t_fixed();
    int n;
    do_reset(0, 0, 8);
    gap(0, n); chk(n == 8, "R6 div 8", n, 8);
    div_value = 1;
    gap(0, n); gap(0, n); chk(n == 1, "R8 div 1", n, 1);
    div_value = 4096;
    gap(0, n); gap(0, n); chk(n == 4096, "R8 div 4096", n, 4096);
    do_reset(1, 0, 8);
    en_alt = 1;
    gap(0, n); chk(n == 16, "R2 R6 gated every other clock", n, 16);
  endtask

  task automatic t_nco();
    int n;
    do_reset(0, 1, 8);
    write_cf(32'h0400_0000);
    load_ofs(32'h0400_0000);
    gap(1, n); gap(1, n); chk(n == 32, "R1 R3 carry period", n, 32);
    gap(0, n); gap(0, n); chk(n == 256, "R7 div 8 of carries", n, 256);
    div_value = 1;
    gap(0, n); gap(0, n); chk(n == 32, "R7 R8 div 1 of carries", n, 32);
  endtask

  initial begin
    t_reset_state();
    t_window_and_wrap();
    t_serial();
    t_fixed();
    t_nco();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule